// File: doc/BRIEF.md
# Dual-Enable Byte-Lane Static RAM Model

This block is a clocked, synthesizable stand-in for an asynchronous 16-bit static RAM. It is meant for system-level simulation or emulation, where a controller needs to see the same mode decode and byte gating as the real memory. The RAM is selected only when an active-low enable is low and an active-high enable is high. Once selected, the write strobe and the output enable pick one of three actions: write, read or outputs disabled. The two byte controls gate each 8-bit lane on its own, for both reads and writes.

All controls are sampled on the rising edge of `clk`. Writes land in storage on the edge where the write condition holds. The write condition holds only for a cycle in which both enables are active and the write strobe is low. Dropping any one of the three ends the write. Reads are returned after `RD_LAT` register stages as a data word plus one drive flag per byte. The drive flags stand in for the high-impedance control of a real bidirectional bus. The address port keeps its full 19-bit width. Only the low `STORE_AW` bits index storage, so a small simulation model still exposes the full interface.

Top module: `byte_lane_sram`

## Requirements
- R1: The address port is 19 bits wide and each word is 16 bits. Storage is indexed by address bits [STORE_AW-1:0] (default 8), and higher address bits are ignored. Words at different indexed addresses are independent.
- R2: When `ce1_n` is 1 or `ce2` is 0, the block is deselected. No byte is driven (`dout_en` = 2'b00) and no storage changes, whatever the other inputs are.
- R3: When the block is selected with `we_n` = 1 and `oe_n` = 1, no byte is driven (`dout_en` = 2'b00).
- R4: When the block is selected with `we_n` = 1 and `oe_n` = 0, it reads the addressed word. `dout_en[0]` = !`lb_n` drives `dout[7:0]`, and `dout_en[1]` = !`ub_n` drives `dout[15:8]`.
- R5: When the block is selected with `we_n` = 0, it writes, whatever `oe_n` is. `din[7:0]` is stored when `lb_n` = 0 and `din[15:8]` when `ub_n` = 0. A byte whose control is 1 keeps its old value.
- R6: No byte is driven (`dout_en` = 2'b00) while a write is being sampled.
- R7: A write happens only on an edge where `ce1_n` = 0, `ce2` = 1 and `we_n` = 0 all hold. If any one of them is inactive on an edge, that edge stores nothing.
- R8: Controls sampled on one rising edge reach `dout`/`dout_en` after `RD_LAT` rising edges, counting the sampling edge (default 2). Before that, the outputs still show the previous request.
- R9: A byte lane whose `dout_en` bit is 0 shows all zeros on its half of `dout`.
- R10: During reset `dout` = 0 and `dout_en` = 2'b00. Stored words survive any length of deselection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| addr | input | 19 | Word address |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte control, active low |
| ub_n | input | 1 | Upper byte control, active low |
| din | input | 16 | Write data |
| dout | output | 16 | Read data; zero in undriven lanes |
| dout_en | output | 2 | Per-lane drive flags, bit 0 lower byte |

## Verification
A wrong mode decode appears on `dout_en` exactly `RD_LAT` edges after the faulty sample. The symptom is a lane that is driven during a write or deselect, or a lane that stays undriven during a read. A wrong write gate only shows up at the next read of that address, as a changed or unchanged byte. The directed tests therefore follow every write variant with a read-back of both lanes. A latency error shows up as a drive flag that changes one edge early or late.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [1:0] {
      MODE_DESEL = 2'd0,
      MODE_OFF   = 2'd1,
      MODE_READ  = 2'd2,
      MODE_WRITE = 2'd3
   } sram_mode_e;

   localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_lane_pkg::*;
#(
   parameter int unsigned LANES = NUM_LANES
) (
   input  logic             ce1_n,
   input  logic             ce2,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [LANES-1:0] lane_n,
   output sram_mode_e       mode,
   output logic [LANES-1:0] wr_lanes,
   output logic [LANES-1:0] rd_lanes
);

   logic selected;

   assign selected = !ce1_n && ce2;

   always_comb begin
      if (!selected)       mode = MODE_DESEL;
      else if (!we_n)      mode = MODE_WRITE;
      else if (!oe_n)      mode = MODE_READ;
      else                 mode = MODE_OFF;
   end

   always_comb begin
      wr_lanes = '0;
      rd_lanes = '0;
      case (mode)
         MODE_WRITE: wr_lanes = ~lane_n;
         MODE_READ:  rd_lanes = ~lane_n;
         default: ;
      endcase
   end

endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned IDX_W  = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [LANE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[idx] <= wdata;
   end

   assign rdata = cells[idx];

endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES*LANE_W-1:0] data_in,
   input  logic [LANES-1:0]        en_in,
   output logic [LANES-1:0]        first_en,
   output logic [LANES*LANE_W-1:0] data_out,
   output logic [LANES-1:0]        en_out
);

   localparam int unsigned WIDTH = LANES * LANE_W;

   logic [WIDTH-1:0] masked;
   logic [WIDTH-1:0] d_q [STAGES];
   logic [LANES-1:0] e_q [STAGES];

   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign masked[l*LANE_W +: LANE_W] = en_in[l] ? data_in[l*LANE_W +: LANE_W] : '0;
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q[0] <= '0;
               e_q[0] <= '0;
            end else begin
               d_q[0] <= masked;
               e_q[0] <= en_in;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q[s] <= '0;
               e_q[s] <= '0;
            end else begin
               d_q[s] <= d_q[s-1];
               e_q[s] <= e_q[s-1];
            end
         end
      end
   end

   assign first_en = e_q[0];
   assign data_out = d_q[STAGES-1];
   assign en_out   = e_q[STAGES-1];

endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W   = 19,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned STORE_AW = 8,
   parameter int unsigned RD_LAT   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       ce1_n,
   input  logic                       ce2,
   input  logic                       we_n,
   input  logic                       oe_n,
   input  logic                       lb_n,
   input  logic                       ub_n,
   input  logic [NUM_LANES*LANE_W-1:0] din,
   output logic [NUM_LANES*LANE_W-1:0] dout,
   output logic [NUM_LANES-1:0]        dout_en
);

   localparam int unsigned LANES  = NUM_LANES;
   localparam int unsigned DATA_W = LANES * LANE_W;

   if (STORE_AW > ADDR_W) begin : g_bad_store
      $error("STORE_AW must not exceed ADDR_W");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end
   if (STORE_AW > 12) begin : g_bad_size
      $error("STORE_AW too large for a model");
   end

   sram_mode_e         mode;
   logic [LANES-1:0]   lane_n;
   logic [LANES-1:0]   wr_lanes;
   logic [LANES-1:0]   rd_lanes;
   logic [LANES-1:0]   stage0_en;
   logic [STORE_AW-1:0] idx;
   logic [DATA_W-1:0]  rword;

   assign lane_n = {ub_n, lb_n};
   assign idx    = addr[STORE_AW-1:0];

   sram_mode_decode #(.LANES(LANES)) u_decode (
      .ce1_n    (ce1_n),
      .ce2      (ce2),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .lane_n   (lane_n),
      .mode     (mode),
      .wr_lanes (wr_lanes),
      .rd_lanes (rd_lanes)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      sram_lane_store #(.LANE_W(LANE_W), .IDX_W(STORE_AW)) u_store (
         .clk   (clk),
         .wr_en (wr_lanes[l]),
         .idx   (idx),
         .wdata (din[l*LANE_W +: LANE_W]),
         .rdata (rword[l*LANE_W +: LANE_W])
      );
   end

   sram_out_pipe #(.LANE_W(LANE_W), .LANES(LANES), .STAGES(RD_LAT)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_in  (rword),
      .en_in    (rd_lanes),
      .first_en (stage0_en),
      .data_out (dout),
      .en_out   (dout_en)
   );

endmodule

// File: rtl/sram_lane_checker.sv
module sram_lane_checker #(
   parameter int unsigned LANE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce1_n,
   input logic              ce2,
   input logic              we_n,
   input logic              oe_n,
   input logic              lb_n,
   input logic              ub_n,
   input logic [1:0]        stage0_en,
   input logic [2*LANE_W-1:0] dout,
   input logic [1:0]        dout_en
);

   AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ce1_n || !ce2)) |-> (stage0_en == 2'b00)); // R2

   AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ce1_n && ce2 && we_n && oe_n)) |-> (stage0_en == 2'b00)); // R3

   AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ce1_n && ce2 && we_n && !oe_n))
      |-> (stage0_en == ~{$past(ub_n), $past(lb_n)})); // R4

   AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ce1_n && ce2 && !we_n)) |-> (stage0_en == 2'b00)); // R6

   AST_LOW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en[0] |-> (dout[LANE_W-1:0] == '0)); // R9

   AST_HIGH_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en[1] |-> (dout[2*LANE_W-1:LANE_W] == '0)); // R9

endmodule

bind byte_lane_sram sram_lane_checker #(.LANE_W(LANE_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce1_n     (ce1_n),
   .ce2       (ce2),
   .we_n      (we_n),
   .oe_n      (oe_n),
   .lb_n      (lb_n),
   .ub_n      (ub_n),
   .stage0_en (stage0_en),
   .dout      (dout),
   .dout_en   (dout_en)
);

// File: tb/test_byte_lane_sram.sv
module test_byte_lane_sram;

   localparam int unsigned LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [18:0] addr = '0;
   logic        ce1_n = 1'b1;
   logic        ce2 = 1'b0;
   logic        we_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        lb_n = 1'b1;
   logic        ub_n = 1'b1;
   logic [15:0] din = '0;
   logic [15:0] dout;
   logic [1:0]  dout_en;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   byte_lane_sram #(.RD_LAT(LAT)) i_byte_lane_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
      .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic go_idle();
      ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
   endtask

   task automatic do_write(input logic [18:0] a, input logic [15:0] d,
                           input logic lbn, input logic ubn, input logic oen,
                           input logic c1n, input logic c2);
      @(negedge clk);
      addr = a; din = d; lb_n = lbn; ub_n = ubn; oe_n = oen;
      ce1_n = c1n; ce2 = c2; we_n = 1'b0;
      @(negedge clk);
      go_idle();
   endtask

   task automatic do_read(input logic [18:0] a, input logic lbn, input logic ubn,
                          input logic [1:0] exp_en, input logic [15:0] exp_d, input string tag);
      @(negedge clk);
      addr = a; lb_n = lbn; ub_n = ubn; oe_n = 1'b0; we_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk(32'(dout_en), 32'(exp_en), {tag, " lanes"});
      chk(32'(dout), 32'(exp_d), {tag, " data"});
      go_idle();
   endtask

   task automatic test_reset();
      chk(32'(dout_en), 0, "R10 reset lanes");
      chk(32'(dout), 0, "R10 reset data");
   endtask

   task automatic test_write_read();
      do_write(19'd5, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      do_read(19'd5, 1'b0, 1'b0, 2'b11, 16'h1234, "R4 R5 full word");
      do_write(19'd5, 16'hFFCD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      do_read(19'd5, 1'b0, 1'b0, 2'b11, 16'h12CD, "R5 low byte write");
      do_write(19'd5, 16'h77EE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      do_read(19'd5, 1'b0, 1'b0, 2'b11, 16'h77CD, "R5 high byte write oe high");
      do_read(19'd5, 1'b1, 1'b0, 2'b10, 16'h7700, "R4 R9 upper only");
      do_read(19'd5, 1'b0, 1'b1, 2'b01, 16'h00CD, "R4 R9 lower only");
      do_read(19'd5, 1'b1, 1'b1, 2'b00, 16'h0000, "R4 no lane");
   endtask

   task automatic test_blocked_writes();
      do_write(19'd5, 16'hDEAD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_read(19'd5, 1'b0, 1'b0, 2'b11, 16'h77CD, "R7 ce2 low blocks write");
      do_write(19'd5, 16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      do_read(19'd5, 1'b0, 1'b0, 2'b11, 16'h77CD, "R2 ce1_n high blocks write");
   endtask

   task automatic test_addresses();
      do_write(19'd7, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      do_read(19'd7, 1'b0, 1'b0, 2'b11, 16'h5555, "R1 second word");
      do_read(19'd5, 1'b0, 1'b0, 2'b11, 16'h77CD, "R1 first word intact");
      do_read(19'h40005, 1'b0, 1'b0, 2'b11, 16'h77CD, "R1 upper bits ignored");
   endtask

   task automatic test_drive_off();
      @(negedge clk);
      addr = 19'd5; lb_n = 1'b0; ub_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk(32'(dout_en), 3, "R4 held read");
      oe_n = 1'b1;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk(32'(dout_en), 0, "R3 output disabled");
      oe_n = 1'b0;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      din = 16'h77CD; we_n = 1'b0;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk(32'(dout_en), 0, "R6 write blocks drive");
      we_n = 1'b1; ce2 = 1'b0;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk(32'(dout_en), 0, "R2 ce2 low deselect");
      ce2 = 1'b1; ce1_n = 1'b1;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk(32'(dout_en), 0, "R2 ce1_n high deselect");
      go_idle();
   endtask

   task automatic test_latency();
      @(negedge clk);
      chk(32'(dout_en), 0, "R8 idle before");
      addr = 19'd7; lb_n = 1'b0; ub_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1;
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      chk(32'(dout_en), 0, "R8 one edge early");
      @(posedge clk);
      @(negedge clk);
      chk(32'(dout), 32'h5555, "R8 on time");
      go_idle();
   endtask

   task automatic test_retention();
      repeat (50) @(negedge clk);
      do_read(19'd7, 1'b0, 1'b0, 2'b11, 16'h5555, "R10 kept while deselected");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_write_read();
      test_blocked_writes();
      test_addresses();
      test_drive_off();
      test_latency();
      test_retention();
      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 20000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule